// File: doc/BRIEF.md
# ADC Sample Output Formatter

This block sits between the converter core and the output pins of a 14-bit sampling ADC. Every sample clock it accepts one conversion result in offset-binary form and turns it into an output word. Small configuration registers decide how that word is built. It can be re-coded to two's complement. It can be scrambled with an XOR randomizer that a receiver undoes. It can be replaced by a fixed or toggling test word. It can be driven on the full 14 lines at once, or folded onto 7 lines carrying two bits each, one per clock half.

A narrow register-write port stands in for the serial configuration slave. A write lands in the configuration registers at one clock edge. The first sample to use the new setting is the one captured at the next edge, so every output word is built under a single setting. The sample path has a fixed latency of two clocks.

Top module: `adc_out_fmt`

## Requirements
- R1: While rst_ni is low, data_o is zero and the configuration returns to offset binary, randomizer off, full-rate packing and no test word.
- R2: With the default setting, a sample captured at clock edge t appears unchanged on data_o after edge t+2.
- R3: Bit 0 of the format register (address 0) set to 1 selects two's complement, which inverts bit 13 of the sample.
- R4: Bit 1 of address 0 enables the randomizer, applied after coding: output bits 13..1 are each XORed with coded bit 0, and bit 0 passes through. A receiver that first takes bit 0 and then XORs the other bits with it recovers the coded word.
- R5: Bit 2 of address 0 selects double-data-rate packing. Line k (k = 0..6) carries word bit 2k+1 while clk_i is high and word bit 2k while clk_i is low. Lines 13..7 are held at zero.
- R6: The test-word register (address 1, bits 2..0) set to code 1 gives 14'h0000 and code 2 gives 14'h3FFF on every sample.
- R7: Code 3 gives a checkerboard. The first word after the test word turns on from off is 14'h2AAA, and it then alternates with 14'h1555 every sample.
- R8: Code 4 gives an alternating pattern. The first word after it turns on from off is 14'h3FFF, and it then alternates with 14'h0000 every sample.
- R9: While a test word is selected, the coding and randomizer settings have no effect on data_o.
- R10: A write accepted at edge E leaves the word shown after E+1 under the old setting and applies the new setting to the word shown after E+2.
- R11: Writes to addresses 2 and 3 change nothing. Test-word codes 0, 5, 6 and 7 mean the live sample is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 14 | Offset-binary conversion result, one per clock |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration register address |
| cfg_wdata_i | input | 3 | Configuration write data |
| data_o | output | 14 | Formatted output lines |

## Verification
The bench builds the block with its default parameters: a 14-bit sample, 7 folded lines and a 2-bit register address. With these values the fixed pattern words 14'h2AAA and 14'h1555 and the 7-line folding can be checked at exact bit positions. The 2-bit address also reaches the two unused addresses, so writes to them can be shown to change nothing. The randomizer is checked by running a receiver model over the output, in addition to comparing against a computed word. The bench samples the folded lines once in each half of the clock.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
  typedef enum logic [2:0] {
    PAT_OFF     = 3'd0,
    PAT_ZEROS   = 3'd1,
    PAT_ONES    = 3'd2,
    PAT_CHECKER = 3'd3,
    PAT_ALT     = 3'd4
  } pat_e;

  typedef struct packed {
    logic twos;
    logic rand_en;
    logic ddr;
    pat_e pat;
  } cfg_t;

  localparam int unsigned ADDR_FMT = 0;
  localparam int unsigned ADDR_PAT = 1;
endpackage

// File: rtl/adc_fmt_cfg.sv
module adc_fmt_cfg
  import adc_fmt_pkg::*;
#(
  parameter int unsigned CFG_AW = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [2:0]        wdata_i,
  output cfg_t              cfg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{twos: 1'b0, rand_en: 1'b0, ddr: 1'b0, pat: PAT_OFF};
    end else if (we_i) begin
      if (addr_i == CFG_AW'(ADDR_FMT)) begin
        cfg_q.twos    <= wdata_i[0];
        cfg_q.rand_en <= wdata_i[1];
        cfg_q.ddr     <= wdata_i[2];
      end else if (addr_i == CFG_AW'(ADDR_PAT)) begin
        case (wdata_i)
          3'd1:    cfg_q.pat <= PAT_ZEROS;
          3'd2:    cfg_q.pat <= PAT_ONES;
          3'd3:    cfg_q.pat <= PAT_CHECKER;
          3'd4:    cfg_q.pat <= PAT_ALT;
          default: cfg_q.pat <= PAT_OFF;
        endcase
      end
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/adc_fmt_pat.sv
module adc_fmt_pat
  import adc_fmt_pkg::*;
#(
  parameter int unsigned DATA_W = 14
) (
  input  pat_e              pat_i,
  input  logic              phase_i,
  output logic [DATA_W-1:0] word_o
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    localparam logic ODD = ((i % 2) == 1);
    always_comb begin
      case (pat_i)
        PAT_ONES:    word_o[i] = 1'b1;
        PAT_CHECKER: word_o[i] = ODD ^ phase_i;
        PAT_ALT:     word_o[i] = ~phase_i;
        default:     word_o[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/adc_fmt_enc.sv
module adc_fmt_enc #(
  parameter int unsigned DATA_W = 14
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic              twos_i,
  input  logic              rand_en_i,
  output logic [DATA_W-1:0] word_o
);
  logic [DATA_W-1:0] coded;

  // offset binary <-> two's complement: flip MSB
  assign coded = word_i ^ {twos_i, {(DATA_W-1){1'b0}}};

  assign word_o[0] = coded[0];
  for (genvar i = 1; i < DATA_W; i++) begin : g_scr
    assign word_o[i] = coded[i] ^ (rand_en_i & coded[0]);
  end
endmodule

// File: rtl/adc_fmt_pack.sv
module adc_fmt_pack #(
  parameter int unsigned DATA_W = 14
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic              ddr_i,
  input  logic              hi_i,
  output logic [DATA_W-1:0] lines_o
);
  localparam int unsigned LANES = DATA_W / 2;

  logic [LANES-1:0] ddr_w;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign ddr_w[k] = hi_i ? word_i[2*k+1] : word_i[2*k];
  end

  assign lines_o = ddr_i ? {{(DATA_W-LANES){1'b0}}, ddr_w} : word_i;
endmodule

// File: rtl/adc_out_fmt.sv
module adc_out_fmt
  import adc_fmt_pkg::*;
#(
  parameter int unsigned DATA_W = 14,
  parameter int unsigned CFG_AW = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [2:0]        cfg_wdata_i,
  output logic [DATA_W-1:0] data_o
);
  cfg_t              cfg_q;
  cfg_t              s1_cfg_q;
  logic [DATA_W-1:0] s1_sample_q;
  logic              s1_phase_q;
  logic              phase_q;
  logic [DATA_W-1:0] pat_word;
  logic [DATA_W-1:0] enc_word;
  logic [DATA_W-1:0] s2_word_q;
  logic              s2_ddr_q;
  pat_e              s1_pat;
  logic              s1_ddr;

  adc_fmt_cfg #(.CFG_AW(CFG_AW)) cfg_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg_q)
  );

  // stage 1: capture sample with the setting in force at this edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_sample_q <= '0;
      s1_cfg_q    <= '{twos: 1'b0, rand_en: 1'b0, ddr: 1'b0, pat: PAT_OFF};
      s1_phase_q  <= 1'b0;
      phase_q     <= 1'b0;
    end else begin
      s1_sample_q <= sample_i;
      s1_cfg_q    <= cfg_q;
      s1_phase_q  <= phase_q;
      phase_q     <= (cfg_q.pat != PAT_OFF) ? ~phase_q : 1'b0;
    end
  end

  assign s1_pat = s1_cfg_q.pat;
  assign s1_ddr = s1_cfg_q.ddr;

  adc_fmt_pat #(.DATA_W(DATA_W)) pat_i (
    .pat_i   (s1_pat),
    .phase_i (s1_phase_q),
    .word_o  (pat_word)
  );

  adc_fmt_enc #(.DATA_W(DATA_W)) enc_i (
    .word_i    (s1_sample_q),
    .twos_i    (s1_cfg_q.twos),
    .rand_en_i (s1_cfg_q.rand_en),
    .word_o    (enc_word)
  );

  // stage 2: formatted word plus its packing mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_word_q <= '0;
      s2_ddr_q  <= 1'b0;
    end else begin
      s2_word_q <= (s1_pat != PAT_OFF) ? pat_word : enc_word;
      s2_ddr_q  <= s1_ddr;
    end
  end

  adc_fmt_pack #(.DATA_W(DATA_W)) pack_i (
    .word_i  (s2_word_q),
    .ddr_i   (s2_ddr_q),
    .hi_i    (clk_i),
    .lines_o (data_o)
  );
endmodule

// File: rtl/adc_out_fmt_chk.sv
module adc_out_fmt_chk
  import adc_fmt_pkg::*;
#(
  parameter int unsigned DATA_W = 14,
  parameter int unsigned CFG_AW = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] sample_i,
  input logic              cfg_we_i,
  input logic [CFG_AW-1:0] cfg_addr_i,
  input logic [DATA_W-1:0] data_o,
  input cfg_t              cfg_q,
  input pat_e              s1_pat,
  input logic              s1_ddr,
  input logic [DATA_W-1:0] s1_sample_q,
  input logic [DATA_W-1:0] s2_word_q,
  input logic              s2_ddr_q
);
  localparam int unsigned LANES = DATA_W / 2;

  logic plain;
  assign plain = !cfg_q.twos && !cfg_q.rand_en && !cfg_q.ddr && (cfg_q.pat == PAT_OFF);

  // R2
  pass_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plain |-> ##2 (data_o == $past(sample_i, 2)));

  // R4
  bit0_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_pat == PAT_OFF && !s1_ddr) |=> (data_o[0] == $past(s1_sample_q[0])));

  // R5
  ddr_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2_ddr_q |-> (data_o[DATA_W-1:LANES] == '0));

  // R6
  ones_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_pat == PAT_ONES && !s1_ddr) |=> (data_o == {DATA_W{1'b1}}));

  // R7
  pat_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((s1_pat == PAT_CHECKER || s1_pat == PAT_ALT) && $past(s1_pat) == s1_pat)
    |=> (s2_word_q == ~$past(s2_word_q)));

  // R11
  bad_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i > CFG_AW'(1)) |=> $stable(cfg_q));
endmodule

bind adc_out_fmt adc_out_fmt_chk #(.DATA_W(DATA_W), .CFG_AW(CFG_AW)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sample_i    (sample_i),
  .cfg_we_i    (cfg_we_i),
  .cfg_addr_i  (cfg_addr_i),
  .data_o      (data_o),
  .cfg_q       (cfg_q),
  .s1_pat      (s1_pat),
  .s1_ddr      (s1_ddr),
  .s1_sample_q (s1_sample_q),
  .s2_word_q   (s2_word_q),
  .s2_ddr_q    (s2_ddr_q)
);

// File: tb/adc_out_fmt_tb_top.sv
`timescale 1ns/1ps
module adc_out_fmt_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [13:0] sample_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_addr_i = '0;
  logic [2:0]  cfg_wdata_i = '0;
  logic [13:0] data_o;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  adc_out_fmt dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .sample_i    (sample_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .data_o      (data_o)
  );

  task automatic chk(string req, logic [13:0] act, logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [2:0] d);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic push_chk(logic [13:0] s, logic [13:0] exp, string req);
    @(negedge clk);
    sample_i = s;
    @(posedge clk); @(posedge clk); #1;
    chk(req, data_o, exp);
  endtask

  function automatic logic [13:0] enc(logic [13:0] s, bit twos, bit rnd);
    logic [13:0] c;
    c = s ^ (twos ? 14'h2000 : 14'h0);
    if (rnd && c[0]) c = c ^ 14'h3FFE;
    return c;
  endfunction

  function automatic logic [13:0] rx_decode(logic [13:0] y);
    logic [13:0] x;
    x = y[0] ? (y ^ 14'h3FFE) : y;
    return x ^ 14'h2000;
  endfunction

  task automatic t_reset();
    #1; chk("R1 reset output", data_o, 14'h0);
    @(negedge clk); rst_ni = 1'b1;
    push_chk(14'h1A5C, 14'h1A5C, "R1 default setting");
  endtask

  task automatic t_pass();
    push_chk(14'h0001, 14'h0001, "R2 pass low");
    push_chk(14'h3FFE, 14'h3FFE, "R2 pass high");
  endtask

  task automatic t_boundary();
    push_chk(14'h0123, 14'h0123, "R10 before write");
    wr(0, 3'b001);
    @(posedge clk); #1; chk("R10 old setting at E+1", data_o, 14'h0123);
    @(posedge clk); #1; chk("R10 new setting at E+2", data_o, 14'h2123);
    push_chk(14'h2000, 14'h0000, "R3 twos MSB inverted");
    wr(0, 3'b000);
  endtask

  task automatic t_rand();
    wr(0, 3'b011);
    for (int i = 0; i < 6; i++) begin
      logic [13:0] s;
      s = 14'(i * 14'h0B57 + 14'h0031);
      push_chk(s, enc(s, 1, 1), "R4 scrambled word");
      chk("R4 receiver recovery", rx_decode(data_o), s);
    end
    wr(0, 3'b000);
  endtask

  task automatic t_ddr();
    logic [13:0] s, hi, lo;
    s = 14'h2D6B;
    hi = '0; lo = '0;
    for (int k = 0; k < 7; k++) begin
      hi[k] = s[2*k+1];
      lo[k] = s[2*k];
    end
    wr(0, 3'b100);
    push_chk(s, hi, "R5 odd bits high half");
    @(negedge clk); #1;
    chk("R5 even bits low half", data_o, lo);
    wr(0, 3'b000);
  endtask

  task automatic t_fixed();
    wr(0, 3'b011);
    wr(1, 3'd1);
    push_chk(14'h1234, 14'h0000, "R6 zeros");
    wr(1, 3'd2);
    push_chk(14'h1234, 14'h3FFF, "R6 ones");
    wr(1, 3'd0);
    wr(0, 3'b000);
  endtask

  task automatic t_checker();
    wr(0, 3'b011);
    wr(1, 3'd3);
    @(posedge clk);
    @(posedge clk); #1; chk("R7 first 2AAA", data_o, 14'h2AAA);
    @(posedge clk); #1; chk("R7 then 1555", data_o, 14'h1555);
    @(posedge clk); #1; chk("R9 bypass coding/rand", data_o, 14'h2AAA);
    wr(1, 3'd0);
    wr(0, 3'b000);
  endtask

  task automatic t_alt();
    wr(1, 3'd4);
    @(posedge clk);
    @(posedge clk); #1; chk("R8 first 3FFF", data_o, 14'h3FFF);
    @(posedge clk); #1; chk("R8 then 0000", data_o, 14'h0000);
    @(posedge clk); #1; chk("R8 back 3FFF", data_o, 14'h3FFF);
    wr(1, 3'd0);
  endtask

  task automatic t_ignore();
    wr(2, 3'b111);
    wr(3, 3'b111);
    push_chk(14'h2F0F, 14'h2F0F, "R11 unused addresses ignored");
    wr(1, 3'd6);
    push_chk(14'h0F0F, 14'h0F0F, "R11 code 6 means live sample");
    wr(1, 3'd0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_pass();
    t_boundary();
    t_rand();
    t_ddr();
    t_fixed();
    t_checker();
    t_alt();
    t_ignore();
    repeat (4) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule